// File: doc/BRIEF.md
# Event Timer Register Front End

This block is the memory-mapped register front end of an event timer. It decodes a 1 KiB window of 32-bit word accesses and holds several kinds of state: a read-only capability word pair, a global configuration register, a status window, a halt-able 64-bit main counter and a bank of per-channel register groups. Comparator arithmetic and interrupt generation live in neighbouring logic. This block drives that logic through configuration outputs, single-cycle write strobes, and arm and cancel pulses.

Software reads and writes the 64-bit counter as two independent 32-bit halves. A read of the low half does not latch the high half. The counter advances by one on each `tick_en` pulse while the global enable is set. While the enable is clear it holds its value, and it resumes from that value when the enable is set again.

The request side carries one word access per cycle. The block has no back-pressure: every cycle with `req_valid` high is accepted and completes. A read returns its data with `rsp_valid` high exactly one cycle later. A write returns no response.

Top module: `evt_timer_regs`

## Requirements
- R1: Every request with `req_valid` high is accepted in its cycle. A read drives `rsp_valid` high with `rsp_rdata` in the following cycle. A write leaves `rsp_valid` low.
- R2: Word 0x000 reads 0x8086A001 with (channel count − 1) placed in bits 12:8, which gives 0x8086A201 for three channels. Word 0x004 reads the tick period parameter, 0x00989680 by default. Writes to both words are ignored.
- R3: In the configuration word at 0x010, bit 0 is the global enable (`glb_enable`) and bit 1 is legacy routing (`legacy_route`). Only these two bits are writable and all other bits read 0. Word 0x014 reads 0 and ignores writes.
- R4: The counter increments by one on each clock edge where `tick_en` and the enable are both high. It holds its value while the enable is low and resumes from that value, carrying from the low half into the high half.
- R5: Word 0x0F0 is the counter low half and word 0x0F4 is the high half. A write replaces only its own half, whether the counter is enabled or not. A write takes precedence over a tick in the same cycle.
- R6: Channel n uses the 32-byte group at 0x100 + 0x20·n. Its configuration word at offset 0 stores only the bits in mask 0x00007F4E and always reads bits 4 and 5 as 1. Offset 4 always reads 0x00000004 and ignores writes.
- R7: In each channel group, offsets 8 and 0xC hold the comparator low and high halves, and offsets 0x10 and 0x14 hold the message route low and high halves. Each half is written independently. A comparator write pulses that channel's `ch_cmp_wr` bit for one cycle, and a configuration write pulses its `ch_cfg_wr` bit.
- R8: When a write sets the enable from 0 to 1, each channel whose comparator is not all ones gets a one-cycle `ch_arm` pulse. When a write clears it from 1 to 0, every channel gets a one-cycle `ch_cancel` pulse. Both pulses coincide with the first cycle of the new `glb_enable` value. Rewriting an unchanged enable gives no pulse.
- R9: Words of channels at or above the channel count, and unimplemented offsets, read 0 and ignore writes.
- R10: Word 0x020 reads `irq_status_in`. A write to it pulses `status_clr` for one cycle with the bits that are set both in the write data and in `irq_status_in`.
- R11: After reset the counter, global configuration and route registers are 0, channel configuration words read 0x00000030, and every comparator reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter tick pulse |
| req_valid | input | 1 | Access request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address within the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| glb_enable | output | 1 | Global enable bit |
| legacy_route | output | 1 | Legacy routing bit |
| counter_value | output | 64 | Main counter |
| irq_status_in | input | NUM_CH | Per-channel interrupt status from interrupt logic |
| status_clr | output | NUM_CH | One-cycle status clear strobes |
| ch_cfg | output | NUM_CH*32 | Channel configuration words, channel 0 lowest |
| ch_cmp | output | NUM_CH*64 | Channel comparators |
| ch_route | output | NUM_CH*64 | Channel message routes |
| ch_cfg_wr | output | NUM_CH | Configuration write strobes |
| ch_cmp_wr | output | NUM_CH | Comparator write strobes |
| ch_arm | output | NUM_CH | Re-arm pulses on enable rise |
| ch_cancel | output | NUM_CH | Cancel pulses on enable fall |

## Verification
The assertions check a set of properties on every cycle. A response never appears without a read in the previous cycle. The counter holds whenever it is neither ticked nor written, steps by exactly one on an enabled tick, and takes a low-half write as written. Arm pulses appear only alongside a set enable and cancel pulses only alongside a clear one. Status clear strobes never name a bit that was not pending. Other behaviours can only be shown by the bench's scenarios. These include the exact register encodings, the write masks, reads of out-of-range channels and unimplemented offsets, which channels get an arm pulse given their comparator contents, the carry across the counter halves, a write winning over a tick in the same cycle, and the values restored by a reset in mid-run.

// File: rtl/evt_regs_pkg.sv
`timescale 1ns/1ps
package evt_regs_pkg;
  localparam int ADDR_W = 10;
  localparam int WORD_W = 32;

  // global word indices (byte address / 4)
  localparam logic [7:0] GW_CAP_LO = 8'h00;
  localparam logic [7:0] GW_CAP_HI = 8'h01;
  localparam logic [7:0] GW_CFG_LO = 8'h04;
  localparam logic [7:0] GW_CFG_HI = 8'h05;
  localparam logic [7:0] GW_STATUS = 8'h08;
  localparam logic [7:0] GW_CNT_LO = 8'h3C;
  localparam logic [7:0] GW_CNT_HI = 8'h3D;

  // word offsets inside a channel group
  localparam logic [2:0] CO_CFG    = 3'd0;
  localparam logic [2:0] CO_ICAP   = 3'd1;
  localparam logic [2:0] CO_CMP_LO = 3'd2;
  localparam logic [2:0] CO_CMP_HI = 3'd3;
  localparam logic [2:0] CO_RT_LO  = 3'd4;
  localparam logic [2:0] CO_RT_HI  = 3'd5;

  localparam logic [31:0] CAP_BASE    = 32'h8086_A001;
  localparam int          CAP_NCH_LSB = 8;

  typedef struct packed {
    logic       chan;    // address lies in the channel area
    logic       ch_hit;  // channel index is implemented
    logic [4:0] ch_idx;
    logic [2:0] ch_off;
    logic [7:0] gword;
  } dec_t;
endpackage

// File: rtl/evt_addr_decode.sv
`timescale 1ns/1ps
module evt_addr_decode
  import evt_regs_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [5:0] NCH = 6'(NUM_CH);

  always_comb begin
    dec.gword  = addr[9:2];
    dec.chan   = |addr[9:8];
    dec.ch_idx = addr[9:5] - 5'd8;
    dec.ch_off = addr[4:2];
    dec.ch_hit = dec.chan && ({1'b0, dec.ch_idx} < NCH);
  end
endmodule

// File: rtl/evt_main_counter.sv
`timescale 1ns/1ps
module evt_main_counter #(
  parameter int HALF = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wdata,
  output logic [2*HALF-1:0] count
);
  localparam int CW = 2 * HALF;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (wr_lo)
      cnt_q[HALF-1:0] <= wdata;
    else if (wr_hi)
      cnt_q[CW-1:HALF] <= wdata;
    else if (run && tick)
      cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;

  a_r4_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!(run && tick) && !wr_lo && !wr_hi) |=> $stable(count));

  a_r4_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !wr_lo && !wr_hi) |=> (count == $past(count) + 1'b1));

  a_r5_low_half_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (count[HALF-1:0] == $past(wdata)));
endmodule

// File: rtl/evt_channel_regs.sv
`timescale 1ns/1ps
module evt_channel_regs
  import evt_regs_pkg::*;
#(
  parameter logic [31:0] CFG_WMASK = 32'h0000_7F4E,
  parameter logic [31:0] CFG_CAPS  = 32'h0000_0030,
  parameter logic [31:0] ICAP_WORD = 32'h0000_0004
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [2:0]  off,
  input  logic [31:0] wdata,
  input  logic        en_rise,
  input  logic        en_fall,
  input  logic        glb_en,
  output logic [31:0] cfg_o,
  output logic [63:0] cmp_o,
  output logic [63:0] route_o,
  output logic [31:0] rdata,
  output logic        arm,
  output logic        cancel,
  output logic        cfg_wr,
  output logic        cmp_wr
);
  logic [31:0] cfg_q;
  logic [63:0] cmp_q;
  logic [63:0] rt_q;
  logic        wr_hit;

  assign wr_hit = sel && wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      cmp_q  <= '1;
      rt_q   <= '0;
      arm    <= 1'b0;
      cancel <= 1'b0;
      cfg_wr <= 1'b0;
      cmp_wr <= 1'b0;
    end else begin
      if (wr_hit && off == CO_CFG)    cfg_q        <= wdata & CFG_WMASK;
      if (wr_hit && off == CO_CMP_LO) cmp_q[31:0]  <= wdata;
      if (wr_hit && off == CO_CMP_HI) cmp_q[63:32] <= wdata;
      if (wr_hit && off == CO_RT_LO)  rt_q[31:0]   <= wdata;
      if (wr_hit && off == CO_RT_HI)  rt_q[63:32]  <= wdata;
      arm    <= en_rise && (cmp_q != '1);
      cancel <= en_fall;
      cfg_wr <= wr_hit && (off == CO_CFG);
      cmp_wr <= wr_hit && (off == CO_CMP_LO || off == CO_CMP_HI);
    end
  end

  assign cfg_o   = cfg_q | CFG_CAPS;
  assign cmp_o   = cmp_q;
  assign route_o = rt_q;

  always_comb begin
    unique case (off)
      CO_CFG:    rdata = cfg_q | CFG_CAPS;
      CO_ICAP:   rdata = ICAP_WORD;
      CO_CMP_LO: rdata = cmp_q[31:0];
      CO_CMP_HI: rdata = cmp_q[63:32];
      CO_RT_LO:  rdata = rt_q[31:0];
      CO_RT_HI:  rdata = rt_q[63:32];
      default:   rdata = '0;
    endcase
  end

  a_r8_arm_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> glb_en);

  a_r8_cancel_with_disable: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> !glb_en);

  a_r8_arm_cancel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(arm && cancel));
endmodule

// File: rtl/evt_timer_regs.sv
`timescale 1ns/1ps
module evt_timer_regs
  import evt_regs_pkg::*;
#(
  parameter int          NUM_CH       = 3,
  parameter logic [31:0] TICK_FS      = 32'h0098_9680,
  parameter logic [31:0] CH_CFG_WMASK = 32'h0000_7F4E,
  parameter logic [31:0] GLB_WMASK    = 32'h0000_0003
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [9:0]           req_addr,
  input  logic [31:0]          req_wdata,
  output logic                 rsp_valid,
  output logic [31:0]          rsp_rdata,
  output logic                 glb_enable,
  output logic                 legacy_route,
  output logic [63:0]          counter_value,
  input  logic [NUM_CH-1:0]    irq_status_in,
  output logic [NUM_CH-1:0]    status_clr,
  output logic [NUM_CH*32-1:0] ch_cfg,
  output logic [NUM_CH*64-1:0] ch_cmp,
  output logic [NUM_CH*64-1:0] ch_route,
  output logic [NUM_CH-1:0]    ch_cfg_wr,
  output logic [NUM_CH-1:0]    ch_cmp_wr,
  output logic [NUM_CH-1:0]    ch_arm,
  output logic [NUM_CH-1:0]    ch_cancel
);
  localparam logic [31:0] CAP_LO = CAP_BASE | (32'(NUM_CH - 1) << CAP_NCH_LSB);

  dec_t        dec;
  logic        wr_req, rd_req;
  logic        gcfg_wr, en_rise, en_fall;
  logic [31:0] gcfg_q;
  logic [31:0] rd_mux;
  logic [31:0] ch_rd [NUM_CH];

  evt_addr_decode #(.NUM_CH(NUM_CH)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  assign wr_req  = req_valid && req_write;
  assign rd_req  = req_valid && !req_write;
  assign gcfg_wr = wr_req && !dec.chan && (dec.gword == GW_CFG_LO);
  assign en_rise = gcfg_wr && req_wdata[0] && !gcfg_q[0];
  assign en_fall = gcfg_wr && !req_wdata[0] && gcfg_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gcfg_q     <= '0;
      status_clr <= '0;
    end else begin
      if (gcfg_wr) gcfg_q <= req_wdata & GLB_WMASK;
      status_clr <= (wr_req && !dec.chan && dec.gword == GW_STATUS)
                    ? (req_wdata[NUM_CH-1:0] & irq_status_in) : '0;
    end
  end

  assign glb_enable   = gcfg_q[0];
  assign legacy_route = gcfg_q[1];

  evt_main_counter #(.HALF(32)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (gcfg_q[0]),
    .tick  (tick_en),
    .wr_lo (wr_req && !dec.chan && dec.gword == GW_CNT_LO),
    .wr_hi (wr_req && !dec.chan && dec.gword == GW_CNT_HI),
    .wdata (req_wdata),
    .count (counter_value)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    evt_channel_regs #(.CFG_WMASK(CH_CFG_WMASK)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (dec.ch_hit && dec.ch_idx == 5'(g)),
      .wr      (wr_req),
      .off     (dec.ch_off),
      .wdata   (req_wdata),
      .en_rise (en_rise),
      .en_fall (en_fall),
      .glb_en  (gcfg_q[0]),
      .cfg_o   (ch_cfg[g*32 +: 32]),
      .cmp_o   (ch_cmp[g*64 +: 64]),
      .route_o (ch_route[g*64 +: 64]),
      .rdata   (ch_rd[g]),
      .arm     (ch_arm[g]),
      .cancel  (ch_cancel[g]),
      .cfg_wr  (ch_cfg_wr[g]),
      .cmp_wr  (ch_cmp_wr[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (dec.chan) begin
      for (int i = 0; i < NUM_CH; i++)
        if (dec.ch_hit && dec.ch_idx == 5'(i)) rd_mux = ch_rd[i];
    end else begin
      case (dec.gword)
        GW_CAP_LO: rd_mux = CAP_LO;
        GW_CAP_HI: rd_mux = TICK_FS;
        GW_CFG_LO: rd_mux = gcfg_q;
        GW_CFG_HI: rd_mux = '0;
        GW_STATUS: rd_mux = 32'(irq_status_in);
        GW_CNT_LO: rd_mux = counter_value[31:0];
        GW_CNT_HI: rd_mux = counter_value[63:32];
        default:   rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_mux;
    end
  end

  a_r1_rsp_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_req));

  a_r3_rise_sets_enable: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> glb_enable);

  a_r10_clear_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_clr) |-> ((status_clr & ~$past(irq_status_in)) == '0));
endmodule

// File: tb/evt_timer_regs_test.sv
`timescale 1ns/1ps
module evt_timer_regs_test;
  localparam int NCH = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_en = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_write = 1'b0;
  logic [9:0]        req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              glb_enable, legacy_route;
  logic [63:0]       counter_value;
  logic [NCH-1:0]    irq_status_in = '0;
  logic [NCH-1:0]    status_clr;
  logic [NCH*32-1:0] ch_cfg;
  logic [NCH*64-1:0] ch_cmp, ch_route;
  logic [NCH-1:0]    ch_cfg_wr, ch_cmp_wr, ch_arm, ch_cancel;

  always #2 clk = ~clk;  // 250 MHz

  evt_timer_regs #(.NUM_CH(NCH)) uut (.*);

  int n_chk = 0;
  int n_err = 0;
  logic [NCH-1:0] s_arm, s_cancel, s_clr, s_cmpwr, s_cfgwr;
  logic           s_rspv;

  typedef struct packed {
    logic        wr;
    logic [9:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 10'h000, 32'h8086A201, 4'd2},  // R2 capability low
    '{1'b0, 10'h004, 32'h00989680, 4'd2},  // R2 period
    '{1'b1, 10'h000, 32'hFFFFFFFF, 4'd2},
    '{1'b0, 10'h000, 32'h8086A201, 4'd2},
    '{1'b1, 10'h004, 32'h00000000, 4'd2},
    '{1'b0, 10'h004, 32'h00989680, 4'd2},
    '{1'b0, 10'h010, 32'h00000000, 4'd11}, // R11 reset values
    '{1'b0, 10'h0F0, 32'h00000000, 4'd11},
    '{1'b0, 10'h0F4, 32'h00000000, 4'd11},
    '{1'b0, 10'h100, 32'h00000030, 4'd11},
    '{1'b0, 10'h104, 32'h00000004, 4'd6},  // R6 interrupt capability
    '{1'b0, 10'h148, 32'hFFFFFFFF, 4'd7},  // R7 comparator reset
    '{1'b0, 10'h14C, 32'hFFFFFFFF, 4'd7},
    '{1'b0, 10'h130, 32'h00000000, 4'd7},
    '{1'b1, 10'h100, 32'hFFFFFFFF, 4'd6},  // R6 write mask
    '{1'b0, 10'h100, 32'h00007F7E, 4'd6},
    '{1'b1, 10'h124, 32'h12345678, 4'd6},
    '{1'b0, 10'h124, 32'h00000004, 4'd6},
    '{1'b1, 10'h130, 32'hDEADBEEF, 4'd7},  // R7 route halves
    '{1'b0, 10'h130, 32'hDEADBEEF, 4'd7},
    '{1'b0, 10'h134, 32'h00000000, 4'd7},
    '{1'b1, 10'h168, 32'h0000ABCD, 4'd9},  // R9 channel 3 absent
    '{1'b0, 10'h168, 32'h00000000, 4'd9},
    '{1'b0, 10'h118, 32'h00000000, 4'd9},
    '{1'b0, 10'h0C0, 32'h00000000, 4'd9},
    '{1'b1, 10'h010, 32'hFFFFFFFF, 4'd3},  // R3 global mask
    '{1'b0, 10'h010, 32'h00000003, 4'd3},
    '{1'b1, 10'h014, 32'hFFFFFFFF, 4'd3},
    '{1'b0, 10'h014, 32'h00000000, 4'd3},
    '{1'b1, 10'h010, 32'h00000002, 4'd3},
    '{1'b0, 10'h010, 32'h00000002, 4'd3},
    '{1'b1, 10'h010, 32'h00000000, 4'd3},
    '{1'b0, 10'h010, 32'h00000000, 4'd3}
  };

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_read(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata; s_rspv = rsp_valid;
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    s_arm = ch_arm; s_cancel = ch_cancel; s_clr = status_clr;
    s_cmpwr = ch_cmp_wr; s_cfgwr = ch_cfg_wr; s_rspv = rsp_valid;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "counter after reset", counter_value, 64'h0);
    check("R11", "enable after reset", {63'h0, glb_enable}, 64'h0);
    check("R11", "ch1 comparator output", ch_cmp[127:64], 64'hFFFFFFFF_FFFFFFFF);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) begin
        bus_write(VECS[i].addr, VECS[i].data);
      end else begin
        bus_read(VECS[i].addr, rd);
        check($sformatf("R%0d", VECS[i].req),
              $sformatf("read %h", VECS[i].addr), {32'h0, rd}, {32'h0, VECS[i].data});
      end
    end

    // R1 response handshake
    bus_read(10'h000, rd);
    check("R1", "rsp_valid after read", {63'h0, s_rspv}, 64'h1);
    bus_write(10'h130, 32'h0);
    check("R1", "rsp_valid after write", {63'h0, s_rspv}, 64'h0);

    // R4 counter run/freeze/resume
    ticks(5);
    check("R4", "no count while disabled", counter_value, 64'h0);
    bus_write(10'h010, 32'h1);
    ticks(7);
    check("R4", "count after 7 ticks", counter_value, 64'd7);
    bus_write(10'h010, 32'h0);
    ticks(4);
    bus_read(10'h0F0, rd);
    check("R4", "frozen counter", {32'h0, rd}, 64'd7);
    bus_write(10'h010, 32'h1);
    ticks(3);
    bus_write(10'h010, 32'h0);
    bus_read(10'h0F0, rd);
    check("R4", "resumed counter", {32'h0, rd}, 64'd10);

    // R5 half writes
    bus_write(10'h0F0, 32'hFFFFFFFE);
    bus_write(10'h0F4, 32'h00000001);
    bus_read(10'h0F0, rd);
    check("R5", "low half", {32'h0, rd}, 64'hFFFFFFFE);
    bus_read(10'h0F4, rd);
    check("R5", "high half", {32'h0, rd}, 64'h1);
    bus_write(10'h010, 32'h1);
    ticks(3);
    bus_write(10'h010, 32'h0);
    check("R4", "carry into high half", counter_value, 64'h2_00000001);

    // R5 write beats tick in the same cycle, while enabled
    bus_write(10'h010, 32'h1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h0F0; req_wdata = 32'h100;
    tick_en = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; tick_en = 1'b0;
    bus_write(10'h010, 32'h0);
    check("R5", "write wins over tick", counter_value, 64'h2_00000100);

    // R8 arm / cancel
    bus_write(10'h128, 32'h10);
    bus_write(10'h12C, 32'h0);
    bus_write(10'h010, 32'h1);
    check("R8", "arm on enable rise", {61'h0, s_arm}, 64'b010);
    check("R8", "no cancel on rise", {61'h0, s_cancel}, 64'b000);
    bus_write(10'h010, 32'h3);
    check("R8", "no arm when already enabled", {61'h0, s_arm}, 64'b000);
    check("R3", "legacy route output", {63'h0, legacy_route}, 64'h1);
    bus_write(10'h010, 32'h0);
    check("R8", "cancel on enable fall", {61'h0, s_cancel}, 64'b111);

    // R7 strobes and comparator output
    bus_write(10'h148, 32'h5);
    check("R7", "comparator strobe", {61'h0, s_cmpwr}, 64'b100);
    check("R7", "ch2 comparator", ch_cmp[191:128], 64'hFFFFFFFF_00000005);
    bus_write(10'h120, 32'h4);
    check("R7", "config strobe", {61'h0, s_cfgwr}, 64'b010);

    // R10 status
    irq_status_in = 3'b101;
    bus_read(10'h020, rd);
    check("R10", "status read", {32'h0, rd}, 64'h5);
    bus_write(10'h020, 32'hFFFFFFFF);
    check("R10", "clear strobe", {61'h0, s_clr}, 64'b101);
    bus_write(10'h020, 32'h2);
    check("R10", "clear of idle bit", {61'h0, s_clr}, 64'b000);

    // R11 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_read(10'h128, rd);
    check("R11", "comparator back to ones", {32'h0, rd}, 64'hFFFFFFFF);
    bus_read(10'h130, rd);
    check("R11", "route back to 0", {32'h0, rd}, 64'h0);
    check("R11", "counter back to 0", counter_value, 64'h0);

    summary();
    $finish;
  end
endmodule